// File: doc/BRIEF.md
# Machine Check Status Register

This block holds the sticky record of asynchronous machine-check errors for a processor core. Seven error-event inputs, one per error class, each latch a dedicated type bit together with a common summary bit. The interrupt request to the core follows the summary bit, gated by the machine-check-enable bit of the machine state register. An error that arrives while machine checks are disabled also latches a separate imprecise flag. The flag is set whether or not the summary bit was already 1.

Software reaches the register through the special-purpose-register port at register number 0x23C. Only supervisor code may use it. A supervisor read returns the register image. A supervisor write clears each bit whose write-data bit is 1. A user-mode access has no effect on the register, returns zero on reads, and raises a privilege-violation signal. Hardware sets always take priority over software clears, so no error can be lost to a racing clear.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, every register bit is 0, `mc_irq_o` is 0 and a supervisor read returns 0x0000_0000.
- R2: A supervisor read with `spr_rd_i`=1 and `spr_addr_i`=0x23C returns the register image on `spr_rdata_o` in the same cycle. The image places the summary at [31] and the imprecise flag at [23]. The type bits are: instruction bus read [30], data bus read [29], data bus write [28], TLB parity [27], instruction cache parity [26], data cache search parity [25], data cache flush parity [24]. Bits [22:0] always read 0. Any other address, or no read strobe, returns 0.
- R3: A 1 on `err_i[k]` sets the summary bit and type bit [30-k] at the next clock edge. The error classes map as: k=0 instruction bus read, k=1 data bus read, k=2 data bus write, k=3 TLB parity, k=4 instruction cache parity, k=5 data cache search parity, k=6 data cache flush parity.
- R4: When several `err_i` bits are 1 in one cycle, every matching type bit is set, together with the single summary bit.
- R5: `mc_irq_o` is 1 exactly while the summary bit and `msr_me_i` are both 1. It follows `msr_me_i` in the same cycle.
- R6: An error cycle with `msr_me_i`=0 sets the imprecise flag [23], including when the summary bit is already 1. An error cycle with `msr_me_i`=1 leaves the flag unchanged.
- R7: A supervisor write to 0x23C clears every bit whose `spr_wdata_i` bit is 1 and keeps every other bit.
- R8: A user-mode read or write to 0x23C changes nothing and returns 0. It drives `priv_viol_o`=1 in the same cycle. Supervisor accesses keep `priv_viol_o` at 0.
- R9: Set bits stay 1 across idle cycles until a clear or a reset.
- R10: If a hardware set and a software clear hit the same bit in one cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 7 | Error events, one per class (see R3) |
| msr_me_i | input | 1 | Machine-check enable from the machine state register |
| spr_super_i | input | 1 | Access is made in supervisor mode |
| spr_rd_i | input | 1 | Special-register read strobe |
| spr_wr_i | input | 1 | Special-register write strobe |
| spr_addr_i | input | 10 | Special-register number |
| spr_wdata_i | input | 32 | Write data; a 1 selects a bit to clear |
| spr_rdata_o | output | 32 | Read data |
| priv_viol_o | output | 1 | User-mode access to this register |
| mc_irq_o | output | 1 | Machine-check interrupt request |

## Verification
A stuck or lost status bit appears on the read port at the first supervisor read after the error cycle. It also appears on `mc_irq_o` in the same cycle, whenever the enable is 1. A wrong set/clear priority shows as a missing type bit in the read that follows a combined clear and error cycle. The imprecise rule is tested both with the summary already set and with it clear. A user-mode access that leaks into the register appears in the next supervisor read.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int unsigned NUM_SRC    = 7;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SPR_ADDR_W = 10;
  localparam logic [SPR_ADDR_W-1:0] SPR_NUM = 10'h23C;
  // big-endian image: summary is bit 0 (MSB), types follow, then imprecise
  localparam int unsigned SUM_IDX = DATA_W - 1;
  localparam int unsigned IMP_IDX = SUM_IDX - NUM_SRC - 1;

  function automatic int unsigned src_idx(input int unsigned k);
    return SUM_IDX - 1 - k;
  endfunction
endpackage

// File: rtl/mcsr_spr_port.sv
module mcsr_spr_port
  import mcsr_pkg::*;
#(
  parameter int unsigned ADDR_W = SPR_ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter logic [ADDR_W-1:0] REG_NUM = SPR_NUM
) (
  input  logic              super_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              rd_ok_o,
  output logic [DW-1:0]     clr_mask_o,
  output logic              priv_viol_o
);
  logic hit;

  assign hit         = (addr_i == REG_NUM);
  assign rd_ok_o     = hit & rd_i & super_i;
  assign clr_mask_o  = (hit & wr_i & super_i) ? wdata_i : '0;
  assign priv_viol_o = hit & (rd_i | wr_i) & ~super_i;
endmodule

// File: rtl/mcsr_set_gen.sv
module mcsr_set_gen
  import mcsr_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC,
  parameter int unsigned DW   = DATA_W
) (
  input  logic [NSRC-1:0] err_i,
  input  logic            me_i,
  output logic [DW-1:0]   set_mask_o
);
  localparam int unsigned SUM = DW - 1;
  localparam int unsigned IMP = SUM - NSRC - 1;

  logic any_err;
  assign any_err = |err_i;

  assign set_mask_o[SUM] = any_err;
  assign set_mask_o[IMP] = any_err & ~me_i;
  assign set_mask_o[IMP-1:0] = '0;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign set_mask_o[SUM-1-k] = err_i[k];
  end
endmodule

// File: rtl/mcsr_sticky_bit.sv
module mcsr_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int unsigned NSRC   = NUM_SRC,
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned ADDR_W = SPR_ADDR_W,
  parameter logic [ADDR_W-1:0] REG_NUM = SPR_NUM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   err_i,
  input  logic              msr_me_i,
  input  logic              spr_super_i,
  input  logic              spr_rd_i,
  input  logic              spr_wr_i,
  input  logic [ADDR_W-1:0] spr_addr_i,
  input  logic [DW-1:0]     spr_wdata_i,
  output logic [DW-1:0]     spr_rdata_o,
  output logic              priv_viol_o,
  output logic              mc_irq_o
);
  localparam int unsigned SUM = DW - 1;
  localparam int unsigned IMP = SUM - NSRC - 1;

  logic          rd_ok;
  logic [DW-1:0] clr_mask;
  logic [DW-1:0] set_mask;
  logic [DW-1:0] status_q;

  mcsr_spr_port #(
    .ADDR_W (ADDR_W),
    .DW     (DW),
    .REG_NUM(REG_NUM)
  ) u_port (
    .super_i    (spr_super_i),
    .rd_i       (spr_rd_i),
    .wr_i       (spr_wr_i),
    .addr_i     (spr_addr_i),
    .wdata_i    (spr_wdata_i),
    .rd_ok_o    (rd_ok),
    .clr_mask_o (clr_mask),
    .priv_viol_o(priv_viol_o)
  );

  mcsr_set_gen #(
    .NSRC(NSRC),
    .DW  (DW)
  ) u_set (
    .err_i     (err_i),
    .me_i      (msr_me_i),
    .set_mask_o(set_mask)
  );

  for (genvar b = IMP; b <= SUM; b++) begin : g_bit
    mcsr_sticky_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_mask[b]),
      .clr_i (clr_mask[b]),
      .q_o   (status_q[b])
    );
  end

  // reserved field
  assign status_q[IMP-1:0] = '0;

  assign spr_rdata_o = rd_ok ? status_q : '0;
  assign mc_irq_o    = status_q[SUM] & msr_me_i;
endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk
  import mcsr_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC,
  parameter int unsigned DW   = DATA_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] err_i,
  input logic            msr_me_i,
  input logic            mc_irq_o,
  input logic [DW-1:0]   status_q,
  input logic [DW-1:0]   clr_mask
);
  localparam int unsigned SUM = DW - 1;
  localparam int unsigned IMP = SUM - NSRC - 1;

  assert_summary_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_i) |=> status_q[SUM]);

  for (genvar k = 0; k < NSRC; k++) begin : g_type
    assert_type_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i[k] |=> status_q[SUM-1-k]);
  end

  assert_irq_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_irq_o == (status_q[SUM] && msr_me_i));

  assert_imprecise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|err_i) && !msr_me_i) |=> status_q[IMP]);

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[IMP-1:0] == '0);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

bind mcsr_unit mcsr_unit_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .err_i   (err_i),
  .msr_me_i(msr_me_i),
  .mc_irq_o(mc_irq_o),
  .status_q(status_q),
  .clr_mask(clr_mask)
);

// File: tb/mcsr_unit_test.sv
module mcsr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] REG = 10'h23C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  err_i = '0;
  logic        msr_me_i = 1'b1;
  logic        spr_super_i = 1'b0;
  logic        spr_rd_i = 1'b0;
  logic        spr_wr_i = 1'b0;
  logic [9:0]  spr_addr_i = '0;
  logic [31:0] spr_wdata_i = '0;
  logic [31:0] spr_rdata_o;
  logic        priv_viol_o;
  logic        mc_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mcsr_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err_i), .msr_me_i(msr_me_i),
    .spr_super_i(spr_super_i), .spr_rd_i(spr_rd_i), .spr_wr_i(spr_wr_i),
    .spr_addr_i(spr_addr_i), .spr_wdata_i(spr_wdata_i),
    .spr_rdata_o(spr_rdata_o), .priv_viol_o(priv_viol_o), .mc_irq_o(mc_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, applied just after the rising edge
  task automatic cyc(input logic [6:0] e, input logic me, input logic rd, input logic wr,
                     input logic sup, input logic [9:0] a, input logic [31:0] wd);
    @(posedge clk_i);
    #1;
    err_i = e; msr_me_i = me; spr_rd_i = rd; spr_wr_i = wr;
    spr_super_i = sup; spr_addr_i = a; spr_wdata_i = wd;
  endtask

  task automatic idle(input logic me);
    cyc('0, me, 1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  // driver: queue the expected read value, then issue the read
  task automatic rd(input logic me, input logic sup, input logic [9:0] a,
                    input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    cyc('0, me, 1'b1, 1'b0, sup, a, '0);
  endtask

  task automatic clr(input logic [31:0] m, input logic [6:0] e, input logic me);
    cyc(e, me, 1'b0, 1'b1, 1'b1, REG, m);
  endtask

  // monitor: pop expected item on every read strobe
  always @(negedge clk_i) begin
    if (rst_ni && spr_rd_i) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected read, got %08h expected none", spr_rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, spr_rdata_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    rd(1, 1, REG, 32'h0000_0000, "R1 reset image");
    #1 chk("R1 irq after reset", {31'b0, mc_irq_o}, 32'h0);

    // instruction bus read error, enable on
    cyc(7'b000_0001, 1, 0, 0, 0, '0, '0);
    rd(1, 1, REG, 32'hC000_0000, "R3 instr bus read bit");
    #1 chk("R5 irq with enable", {31'b0, mc_irq_o}, 32'h1);
    idle(0);
    #1 chk("R5 irq enable off", {31'b0, mc_irq_o}, 32'h0);

    clr(32'hC000_0000, '0, 1);
    #1 chk("R8 no viol for supervisor write", {31'b0, priv_viol_o}, 32'h0);
    rd(1, 1, REG, 32'h0000_0000, "R7 full clear");

    // TLB parity and dcache flush parity together
    cyc(7'b100_1000, 1, 0, 0, 0, '0, '0);
    rd(1, 1, REG, 32'h8900_0000, "R4 two types at once");
    clr(32'h0800_0000, '0, 1);
    rd(1, 1, REG, 32'h8100_0000, "R7 partial clear");
    repeat (5) idle(1);
    rd(1, 1, REG, 32'h8100_0000, "R9 held over idle");

    // user-mode access
    cyc('0, 1, 0, 1, 0, REG, 32'hFFFF_FFFF);
    #1 chk("R8 viol on user write", {31'b0, priv_viol_o}, 32'h1);
    rd(1, 0, REG, 32'h0000_0000, "R8 user read is zero");
    #1 chk("R8 viol on user read", {31'b0, priv_viol_o}, 32'h1);
    rd(1, 1, REG, 32'h8100_0000, "R8 user write ignored");
    rd(1, 1, 10'h23D, 32'h0000_0000, "R2 other address");

    // error while disabled
    clr(32'hFFFF_FFFF, '0, 1);
    cyc(7'b000_0010, 0, 0, 0, 0, '0, '0);
    rd(0, 1, REG, 32'hA080_0000, "R6 imprecise with data read");
    #1 chk("R5 irq low while disabled", {31'b0, mc_irq_o}, 32'h0);
    idle(1);
    #1 chk("R5 irq on enable", {31'b0, mc_irq_o}, 32'h1);

    // summary already set, then a disabled error
    clr(32'hFFFF_FFFF, '0, 1);
    cyc(7'b000_0100, 1, 0, 0, 0, '0, '0);
    rd(1, 1, REG, 32'h9000_0000, "R6 no imprecise when enabled");
    cyc(7'b001_0000, 0, 0, 0, 0, '0, '0);
    rd(1, 1, REG, 32'h9480_0000, "R6 imprecise with summary set");

    // set beats clear
    clr(32'hFFFF_FFFF, 7'b010_0000, 1);
    rd(1, 1, REG, 32'h8200_0000, "R10 set wins over clear");

    // every source, reserved field
    clr(32'hFFFF_FFFF, '0, 1);
    cyc(7'b111_1111, 1, 0, 0, 0, '0, '0);
    rd(1, 1, REG, 32'hFF00_0000, "R4 all sources, R2 reserved zero");

    idle(1);
    idle(1);
    chk("scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule